// File: doc/BRIEF.md
# Processor Host Register Slave

This block sits between an AXI4-Lite host port and a small single-instruction processor core. Software uses it to load the core's sixteen instruction words, set or clear the core's run and reset controls, and poll a completion flag. It also reads back a debug word, the count of executed instructions and a fixed identification constant.

The core's 32-entry register file is not mapped directly. Software first writes a data word and then writes a selector register that holds an entry number and a write-request bit. The block turns this into a one-cycle write pulse toward the core. A read of the read-back register returns whichever entry the selector currently names.

Program and register-file access is allowed only while the core is stopped, so the host and the core never write at the same time. Every transfer is single-beat and always answers OKAY.

Top module: `proc_csr_axil`

## Requirements
- R1: After reset all instruction words, the control bits, the selector and the data register are zero. `run_en`, `core_rst`, `rf_we`, `s_bvalid` and `s_rvalid` are low.
- R2: While enable is clear, a write to byte offset 4*k (k = 0..15) sets instruction word k. Word k reads back at that offset and appears on `imem_flat[32k+31:32k]`.
- R3: Write strobes act byte by byte on every writable register. Strobe bit i governs data bits 8i+7..8i, and a byte whose strobe is clear keeps its old value.
- R4: At offset 0x40, bit 0 is enable and drives `run_en`. Bit 1 drives `core_rst`. Bit 2 reads `core_done`, and writing it has no effect. All other bits read zero. This register is writable at all times.
- R5: At offset 0x44, bits 4..0 hold the register-file entry number, which appears on `rf_addr`. Bit 8 holds the write request. All other bits read zero.
- R6: The write pulse comes in the cycle after an accepted write to 0x44 or 0x48, but only when the write request at 0x44 is set once that write has landed. `rf_we` is then high for exactly one cycle, with `rf_wdata` equal to the value at 0x48. No pulse is ever issued for entry 0.
- R7: A read of 0x4C returns `rf_rdata`, which is the entry selected at 0x44.
- R8: Offset 0x74 returns `core_debug` and offset 0x78 returns `core_icount`. Offset 0x7C always returns 0x0DEBAC7E. Writes to these three offsets have no effect.
- R9: Offsets 0x50 to 0x70 read as zero and ignore writes.
- R10: While enable is set, writes to 0x00-0x3C, 0x44 and 0x48 are ignored. Reads of 0x00-0x3C, 0x44, 0x48 and 0x4C return zero.
- R11: A write is accepted only in a cycle where both address and data are valid. `s_bvalid` rises in the next cycle and holds until `s_bready`. Read data comes in the cycle after the address handshake, is held stable until `s_rready`, and both responses are OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| run_en | output | 1 | Core enable (control bit 0) |
| core_rst | output | 1 | Core reset request (control bit 1) |
| core_done | input | 1 | Core completion flag |
| core_debug | input | 32 | Core debug word |
| core_icount | input | 32 | Executed-instruction count |
| imem_flat | output | 32*N_INSTR | Instruction words, word k at bits 32k+31..32k |
| rf_addr | output | RF_AW | Register-file entry number |
| rf_wdata | output | 32 | Register-file write data |
| rf_we | output | 1 | Register-file write pulse |
| rf_rdata | input | 32 | Register-file read data for rf_addr |

## Verification
Register contents change at the clock edge that accepts a write. The bench therefore samples `imem_flat`, `run_en` and `core_rst` at the falling edge that follows the handshake. The `rf_we` pulse is due one cycle after that handshake edge, so the bench samples it at that same falling edge and again one cycle later to confirm it has dropped. Read data is registered at the address handshake edge and sampled at the next falling edge. Each held response is checked over two extra cycles while its ready is low.

// File: rtl/proc_csr_pkg.sv
package proc_csr_pkg;
  localparam int IDX_W       = 5;   // word index within the 32-word map
  localparam int INSTR_SLOTS = 16;
  localparam logic [IDX_W-1:0] IX_CTRL  = 5'd16;
  localparam logic [IDX_W-1:0] IX_RFSEL = 5'd17;
  localparam logic [IDX_W-1:0] IX_RFDAT = 5'd18;
  localparam logic [IDX_W-1:0] IX_RFRD  = 5'd19;
  localparam logic [IDX_W-1:0] IX_DEBUG = 5'd29;
  localparam logic [IDX_W-1:0] IX_COUNT = 5'd30;
  localparam logic [IDX_W-1:0] IX_IDENT = 5'd31;
  localparam int SEL_WE_BIT = 8;

  typedef enum logic [3:0] {
    SEL_INSTR, SEL_CTRL, SEL_RFSEL, SEL_RFDAT, SEL_RFRD,
    SEL_DEBUG, SEL_COUNT, SEL_IDENT, SEL_NONE
  } csr_sel_e;

  function automatic csr_sel_e decode_idx(input logic [IDX_W-1:0] idx);
    if (int'(idx) < INSTR_SLOTS) return SEL_INSTR;
    case (idx)
      IX_CTRL:  return SEL_CTRL;
      IX_RFSEL: return SEL_RFSEL;
      IX_RFDAT: return SEL_RFDAT;
      IX_RFRD:  return SEL_RFRD;
      IX_DEBUG: return SEL_DEBUG;
      IX_COUNT: return SEL_COUNT;
      IX_IDENT: return SEL_IDENT;
      default:  return SEL_NONE;
    endcase
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/proc_csr_wr_chan.sv
module proc_csr_wr_chan
  import proc_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_fire,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb
);
  logic pair_ok;
  assign pair_ok = awvalid && wvalid && !bvalid;
  assign awready = pair_ok;
  assign wready  = pair_ok;
  assign wr_fire = pair_ok;
  assign wr_idx  = awaddr[IDX_W+1:2];
  assign wr_data = wdata;
  assign wr_strb = wstrb;
  assign bresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)        bvalid <= 1'b0;
    else if (wr_fire)  bvalid <= 1'b1;
    else if (bready)   bvalid <= 1'b0;
  end

  AST_AW_WITH_W: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready) |-> (wvalid && wready)); // R11
  AST_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> bvalid); // R11
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid); // R11
endmodule

// File: rtl/proc_csr_rd_chan.sv
module proc_csr_rd_chan
  import proc_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [31:0]       rd_value
);
  logic rd_fire;
  assign arready = !rvalid;
  assign rd_fire = arvalid && arready;
  assign rd_idx  = araddr[IDX_W+1:2];
  assign rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_fire) begin
      rvalid <= 1'b1;
      rdata  <= rd_value;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  AST_R_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid); // R11
  AST_R_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R11
endmodule

// File: rtl/proc_csr_store.sv
module proc_csr_store
  import proc_csr_pkg::*;
#(
  parameter int          N_INSTR = 16,
  parameter int          RF_AW   = 5,
  parameter logic [31:0] ID_WORD = 32'h0DEB_AC7E
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [31:0]           wr_data,
  input  logic [3:0]            wr_strb,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [31:0]           rd_value,
  output logic                  run_en,
  output logic                  core_rst,
  input  logic                  core_done,
  input  logic [31:0]           core_debug,
  input  logic [31:0]           core_icount,
  output logic [32*N_INSTR-1:0] imem_flat,
  output logic [RF_AW-1:0]      rf_addr,
  output logic [31:0]           rf_wdata,
  output logic                  rf_we,
  input  logic [31:0]           rf_rdata
);
  localparam int SLOT_W = (N_INSTR > 1) ? $clog2(N_INSTR) : 1;

  logic [31:0]      instr_q [N_INSTR];
  logic [1:0]       ctrl_q;
  logic [RF_AW-1:0] sel_addr_q;
  logic             sel_we_q;
  logic [31:0]      rfdat_q;
  logic             rf_touch_q;

  csr_sel_e    wsel, rsel;
  logic        locked;
  logic        host_rf_touch;
  logic [31:0] ctrl_view, sel_view, sel_merged;

  assign locked    = ctrl_q[0];
  assign wsel      = decode_idx(wr_idx);
  assign rsel      = decode_idx(rd_idx);
  assign ctrl_view = {29'b0, core_done, ctrl_q};
  always_comb begin
    sel_view = '0;
    sel_view[RF_AW-1:0]  = sel_addr_q;
    sel_view[SEL_WE_BIT] = sel_we_q;
  end
  assign sel_merged    = merge_bytes(sel_view, wr_data, wr_strb);
  assign host_rf_touch = wr_fire && !locked && (wsel == SEL_RFSEL || wsel == SEL_RFDAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_INSTR; i++) instr_q[i] <= '0;
      ctrl_q     <= '0;
      sel_addr_q <= '0;
      sel_we_q   <= 1'b0;
      rfdat_q    <= '0;
      rf_touch_q <= 1'b0;
    end else begin
      rf_touch_q <= host_rf_touch;
      if (wr_fire) begin
        case (wsel)
          SEL_INSTR:
            if (!locked)
              for (int i = 0; i < N_INSTR; i++)
                if (int'(wr_idx) == i) instr_q[i] <= merge_bytes(instr_q[i], wr_data, wr_strb);
          SEL_CTRL:  ctrl_q <= merge_bytes(ctrl_view, wr_data, wr_strb) & 32'h3;
          SEL_RFSEL:
            if (!locked) begin
              sel_addr_q <= sel_merged[RF_AW-1:0];
              sel_we_q   <= sel_merged[SEL_WE_BIT];
            end
          SEL_RFDAT: if (!locked) rfdat_q <= merge_bytes(rfdat_q, wr_data, wr_strb);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_value = '0;
    case (rsel)
      SEL_INSTR:
        if (!locked && int'(rd_idx) < N_INSTR) rd_value = instr_q[rd_idx[SLOT_W-1:0]];
      SEL_CTRL:  rd_value = ctrl_view;
      SEL_RFSEL: if (!locked) rd_value = sel_view;
      SEL_RFDAT: if (!locked) rd_value = rfdat_q;
      SEL_RFRD:  if (!locked) rd_value = rf_rdata;
      SEL_DEBUG: rd_value = core_debug;
      SEL_COUNT: rd_value = core_icount;
      SEL_IDENT: rd_value = ID_WORD;
      default:   rd_value = '0;
    endcase
  end

  for (genvar g = 0; g < N_INSTR; g++) begin : g_imem
    assign imem_flat[32*g +: 32] = instr_q[g];
  end

  assign run_en   = ctrl_q[0];
  assign core_rst = ctrl_q[1];
  assign rf_addr  = sel_addr_q;
  assign rf_wdata = rfdat_q;
  assign rf_we    = rf_touch_q && sel_we_q && (sel_addr_q != '0);

  AST_RF_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we); // R6
  AST_RF_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(host_rf_touch)); // R6
  AST_RF_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_addr != '0)); // R6
  AST_LOCK_IMEM: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(imem_flat)); // R10
endmodule

// File: rtl/proc_csr_axil.sv
module proc_csr_axil
  import proc_csr_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter int          N_INSTR = 16,
  parameter int          RF_AW   = 5,
  parameter logic [31:0] ID_WORD = 32'h0DEB_AC7E
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [31:0]           s_wdata,
  input  logic [3:0]            s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [31:0]           s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic                  run_en,
  output logic                  core_rst,
  input  logic                  core_done,
  input  logic [31:0]           core_debug,
  input  logic [31:0]           core_icount,
  output logic [32*N_INSTR-1:0] imem_flat,
  output logic [RF_AW-1:0]      rf_addr,
  output logic [31:0]           rf_wdata,
  output logic                  rf_we,
  input  logic [31:0]           rf_rdata
);
  logic             wr_fire;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [31:0]      wr_data, rd_value;
  logic [3:0]       wr_strb;

  proc_csr_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  proc_csr_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_idx(rd_idx), .rd_value(rd_value)
  );

  proc_csr_store #(.N_INSTR(N_INSTR), .RF_AW(RF_AW), .ID_WORD(ID_WORD)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_value(rd_value),
    .run_en(run_en), .core_rst(core_rst), .core_done(core_done),
    .core_debug(core_debug), .core_icount(core_icount), .imem_flat(imem_flat),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );
endmodule

// File: tb/proc_csr_axil_bench.sv
module proc_csr_axil_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        run_en, core_rst, rf_we;
  logic        core_done = 1'b0;
  logic [31:0] core_debug = '0, core_icount = '0;
  logic [32*NI-1:0] imem_flat;
  logic [4:0]  rf_addr;
  logic [31:0] rf_wdata, rf_rdata;
  logic [31:0] rf_model [32];

  int checks = 0, errors = 0;
  logic we_after, we_next;
  logic [31:0] wd_after;
  logic [4:0]  wa_after;
  logic [1:0]  bresp_seen;
  logic        bv_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  proc_csr_axil u_proc_csr_axil (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .run_en(run_en), .core_rst(core_rst), .core_done(core_done),
    .core_debug(core_debug), .core_icount(core_icount), .imem_flat(imem_flat),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  // simple register-file model standing in for the core
  initial for (int i = 0; i < 32; i++) rf_model[i] = '0;
  always @(posedge clk) if (rf_we) rf_model[rf_addr] <= rf_wdata;
  assign rf_rdata = rf_model[rf_addr];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic axw(input logic [6:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; awvalid = 1'b1; wdata = d; wstrb = s; wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    we_after = rf_we; wd_after = rf_wdata; wa_after = rf_addr;
    bresp_seen = bresp; bv_seen = bvalid;
    @(posedge clk);
    @(negedge clk);
    we_next = rf_we;
  endtask

  task automatic axr(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata;
    check("R11 rvalid after ar", {31'b0, rvalid}, 32'd1);
    check("R11 rresp okay", {30'b0, rresp}, 32'd0);
    @(posedge clk);
  endtask

  // {slot[3:0], data[31:0], strb[3:0], expected[31:0]}
  localparam logic [71:0] VEC [7] = '{
    {4'd0,  32'h1201_0001, 4'hF, 32'h1201_0001},
    {4'd1,  32'h3102_0201, 4'hF, 32'h3102_0201},
    {4'd15, 32'hE300_0001, 4'hF, 32'hE300_0001},
    {4'd1,  32'hAABB_CCDD, 4'h5, 32'h31BB_02DD},
    {4'd15, 32'h1122_3344, 4'hA, 32'h1100_3301},
    {4'd7,  32'h5A5A_5A5A, 4'h0, 32'h0000_0000},
    {4'd3,  32'h0003_0301, 4'hF, 32'h0003_0301}
  };

  logic done_flag = 1'b0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd, hold;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 bvalid", {31'b0, bvalid}, 32'd0);
    check("R1 rvalid", {31'b0, rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 run_en/core_rst/rf_we", {29'b0, run_en, core_rst, rf_we}, 32'd0);
    check("R1 imem zero", {31'b0, |imem_flat}, 32'd0);
    axr(7'h40, rd); check("R1 ctrl zero", rd, 32'd0);
    axr(7'h44, rd); check("R1 selector zero", rd, 32'd0);

    // R2 / R3 table of instruction writes
    foreach (VEC[v]) begin
      logic [3:0] slot;
      slot = VEC[v][71:68];
      axw({1'b0, slot, 2'b00}, VEC[v][67:36], VEC[v][35:32]);
      check("R11 bresp okay", {30'b0, bresp_seen}, 32'd0);
      check("R11 bvalid after write", {31'b0, bv_seen}, 32'd1);
      axr({1'b0, slot, 2'b00}, rd);
      check("R2 R3 instr readback", rd, VEC[v][31:0]);
      check("R2 imem slice", imem_flat[32*slot +: 32], VEC[v][31:0]);
    end

    // R4 control register
    axw(7'h40, 32'hFFFF_FFFF, 4'hF);
    check("R4 run_en/core_rst", {30'b0, run_en, core_rst}, 32'd3);
    axr(7'h40, rd); check("R4 ctrl read done low", rd, 32'd3);
    core_done = 1'b1;
    axr(7'h40, rd); check("R4 ctrl read done high", rd, 32'd7);

    // R10 locked accesses
    axw(7'h00, 32'hDEAD_BEEF, 4'hF);
    axr(7'h00, rd); check("R10 instr read hidden", rd, 32'd0);
    axw(7'h48, 32'h7777_7777, 4'hF);
    axw(7'h44, 32'h0000_0102, 4'hF);
    check("R10 no rf pulse while locked", {31'b0, we_after}, 32'd0);
    axr(7'h44, rd); check("R10 selector read hidden", rd, 32'd0);
    axw(7'h40, 32'h0000_0000, 4'hF);
    check("R4 stop", {30'b0, run_en, core_rst}, 32'd0);
    axr(7'h00, rd); check("R10 instr kept", rd, 32'h1201_0001);
    axr(7'h44, rd); check("R10 selector kept", rd, 32'd0);
    axr(7'h48, rd); check("R10 data kept", rd, 32'd0);
    // R3 strobe on control: only byte1 enabled, bit0 unchanged
    axw(7'h40, 32'hFFFF_FFFF, 4'h2);
    check("R3 ctrl strobe masked", {31'b0, run_en}, 32'd0);

    // R5 R6 R7 register-file access
    axw(7'h48, 32'hCAFE_F00D, 4'hF);
    check("R6 no pulse without request", {31'b0, we_after}, 32'd0);
    axw(7'h44, 32'h0000_0103, 4'hF);
    check("R6 pulse", {31'b0, we_after}, 32'd1);
    check("R6 pulse data", wd_after, 32'hCAFE_F00D);
    check("R5 rf_addr", {27'b0, wa_after}, 32'd3);
    check("R6 pulse one cycle", {31'b0, we_next}, 32'd0);
    axr(7'h4C, rd); check("R7 readback entry 3", rd, 32'hCAFE_F00D);
    axw(7'h48, 32'h0BAD_0001, 4'h3);
    check("R6 pulse on data write", {31'b0, we_after}, 32'd1);
    check("R3 R6 merged data", wd_after, 32'hCAFE_0001);
    axw(7'h44, 32'hFFFF_FFFF, 4'hF);
    axr(7'h44, rd); check("R5 selector mask", rd, 32'h0000_011F);
    axw(7'h44, 32'h0000_0100, 4'hF);
    check("R6 no pulse entry 0", {31'b0, we_after}, 32'd0);
    axr(7'h4C, rd); check("R6 entry 0 zero", rd, 32'd0);
    axw(7'h44, 32'h0000_0003, 4'hF);
    axw(7'h48, 32'h1111_2222, 4'hF);
    check("R6 no pulse request clear", {31'b0, we_after}, 32'd0);
    axr(7'h4C, rd); check("R7 entry 3 kept", rd, 32'hCAFE_0001);
    axw(7'h40, 32'h1, 4'hF);
    axr(7'h4C, rd); check("R10 rf read hidden", rd, 32'd0);
    axw(7'h40, 32'h0, 4'hF);

    // R8 core status and identity
    core_debug = 32'h0000_1234; core_icount = 32'h0000_0056;
    axw(7'h7C, 32'h0, 4'hF);
    axw(7'h74, 32'hFFFF_FFFF, 4'hF);
    axr(7'h74, rd); check("R8 debug", rd, 32'h0000_1234);
    axr(7'h78, rd); check("R8 count", rd, 32'h0000_0056);
    axr(7'h7C, rd); check("R8 ident", rd, 32'h0DEB_AC7E);

    // R9 reserved
    axw(7'h50, 32'hFFFF_FFFF, 4'hF);
    axw(7'h70, 32'hFFFF_FFFF, 4'hF);
    axr(7'h50, rd); check("R9 reserved 0x50", rd, 32'd0);
    axr(7'h70, rd); check("R9 reserved 0x70", rd, 32'd0);
    check("R9 imem untouched", imem_flat[31:0], 32'h1201_0001);

    // R11 address without data is not accepted
    @(negedge clk);
    awaddr = 7'h08; awvalid = 1'b1; wdata = 32'h2468_ACE0; wstrb = 4'hF;
    repeat (3) begin
      @(negedge clk);
      check("R11 no accept without data", {30'b0, awready, bvalid}, 32'd0);
    end
    wvalid = 1'b1;
    #1 check("R11 ready with both", {30'b0, awready, wready}, 32'd3);
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    @(posedge clk);
    axr(7'h08, rd); check("R11 late-data write landed", rd, 32'h2468_ACE0);

    // R11 response held while not ready
    bready = 1'b0;
    @(negedge clk);
    awaddr = 7'h60; awvalid = 1'b1; wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 bvalid held", {31'b0, bvalid}, 32'd1);
    bready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11 bvalid released", {31'b0, bvalid}, 32'd0);

    rready = 1'b0;
    araddr = 7'h7C; arvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    hold = rdata;
    repeat (2) @(negedge clk);
    check("R11 rvalid held", {30'b0, rvalid, arready}, 32'd2);
    check("R11 rdata stable", rdata, hold);
    rready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11 rvalid released", {31'b0, rvalid}, 32'd0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule